// File: doc/BRIEF.md
# Video Status Word: Vertical Blank and Field Bits

This block builds the part of a video processor's status word that a host reads to learn where the raster is. It takes the current line number, the horizontal slot within the line, the horizontal width mode, the 50 Hz timing mode, the display-enable setting and the interlace setting. From these it decodes a vertical-blank bit and an odd-field bit. The FIFO, transfer-busy and sprite-collision bits come in on plain input ports and are merged into the same word.

The vertical-blank bit does not change on line boundaries. It rises two slots after the line-change slot on the first inactive line. It falls at the same point on line 0x1FF, the pre-display line that the counter reaches before it wraps to line 0. Clearing the display-enable setting forces the bit high.

The odd-field state flips on each frame strobe while interlace is enabled. It is cleared whenever interlace is disabled.

A host read is a one-cycle strobe. The word is sampled in the strobe cycle, appears on the read-data output one clock later, and is held there until the next strobe.

Top module: `vid_status_flags`

## Requirements
- R1: After reset, rd_data_o is all zeros, rd_valid_o is low, and the odd-field state is cleared.
- R2: With the display enabled, bit 3 (0x8) of the word is 1 on every line strictly greater than the first inactive line and strictly less than 0x1FF, for any slot. The first inactive line is 224 when pal_i is 0 and 240 when pal_i is 1.
- R3: On the first inactive line, with the display enabled, bit 3 is 1 when the slot is at or above the line-change slot plus 2, or below the line-change slot. It is 0 for the line-change slot and the slot after it. The line-change slot is 165 when wide_i is 1 and 132 when wide_i is 0.
- R4: On line 0x1FF, with the display enabled, bit 3 is 1 only for the line-change slot and the slot after it. It is 0 for every other slot.
- R5: With the display enabled, bit 3 is 0 on every line below the first inactive line, for any slot. In 50 Hz mode this includes lines 224 to 239.
- R6: When disp_en_i is 0, bit 3 is 1 on every line and slot.
- R7: Bit 4 (0x10) is 1 only when interlace_i is 1 and the odd-field state is set.
  - While interlace_i is 1, each cycle with frame_stb_i high flips the odd-field state at the clock edge.
  - Any cycle with interlace_i low clears the odd-field state.
- R8: A cycle with rd_stb_i high samples the word from that cycle's inputs. The sampled word appears on rd_data_o after the next clock edge, with rd_valid_o high for exactly that one cycle. rd_data_o then holds its value until the next strobe, whatever the inputs do.
- R9: The remaining fields of the word are:
  - bit 0 = dma_busy_i
  - bit 5 = sprite_hit_i
  - bit 8 = fifo_empty_i
  - bit 9 = fifo_full_i
  - every other bit is 0.
- R10: When rd_stb_i and frame_stb_i are high in the same cycle, the sampled bit 4 reflects the odd-field state from before that frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 9 | Current line number |
| slot_i | input | 8 | Current horizontal slot |
| wide_i | input | 1 | 1 = 40-cell width mode, 0 = 32-cell width mode |
| pal_i | input | 1 | 1 = 50 Hz line timing |
| disp_en_i | input | 1 | Display enable |
| interlace_i | input | 1 | Interlace enable |
| frame_stb_i | input | 1 | One-cycle frame boundary strobe |
| rd_stb_i | input | 1 | Host status read strobe |
| dma_busy_i | input | 1 | Transfer busy flag, passed to bit 0 |
| sprite_hit_i | input | 1 | Sprite collision flag, passed to bit 5 |
| fifo_empty_i | input | 1 | FIFO empty flag, passed to bit 8 |
| fifo_full_i | input | 1 | FIFO full flag, passed to bit 9 |
| rd_data_o | output | 16 | Status word sampled at the last read strobe |
| rd_valid_o | output | 1 | High for one cycle when rd_data_o is refreshed |

## Verification
A host read and a frame strobe can land in the same clock. The read must then report the field parity from before the flip, and the flip must still take effect.

The bench provokes this by raising both strobes in one cycle with interlace on and a known parity. It checks that the returned bit 4 holds the old parity. A plain read straight afterwards must show the new parity.

A second collision mixes a read with interlace dropping in the same cycle. Bit 4 must read 0 there, and the cleared state must persist on the following read.

// File: rtl/vid_status_flags.sv
module vid_status_flags #(
  parameter int LINE_W      = 9,
  parameter int SLOT_W      = 8,
  parameter int WORD_W      = 16,
  parameter int NTSC_FIRST  = 224,
  parameter int PAL_FIRST   = 240,
  parameter int WIDE_CHG    = 165,
  parameter int NARROW_CHG  = 132,
  parameter int VB_OFFSET   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              wide_i,
  input  logic              pal_i,
  input  logic              disp_en_i,
  input  logic              interlace_i,
  input  logic              frame_stb_i,
  input  logic              rd_stb_i,
  input  logic              dma_busy_i,
  input  logic              sprite_hit_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o
);

  localparam logic [LINE_W-1:0] WRAP_LINE = '1;

  logic [SLOT_W-1:0] chg_slot, vb_slot;
  logic [LINE_W-1:0] first_blank;
  logic in_body, on_first, on_wrap, vblank;
  logic odd_q;
  logic [WORD_W-1:0] word;

  assign chg_slot    = wide_i ? SLOT_W'(WIDE_CHG) : SLOT_W'(NARROW_CHG);
  assign vb_slot     = chg_slot + SLOT_W'(VB_OFFSET);
  assign first_blank = pal_i ? LINE_W'(PAL_FIRST) : LINE_W'(NTSC_FIRST);

  assign in_body  = (line_i > first_blank) && (line_i < WRAP_LINE);
  assign on_first = (line_i == first_blank) && ((slot_i >= vb_slot) || (slot_i < chg_slot));
  assign on_wrap  = (line_i == WRAP_LINE) && (slot_i >= chg_slot) && (slot_i < vb_slot);
  assign vblank   = in_body || on_first || on_wrap || !disp_en_i;

  always_ff @(posedge clk) begin
    if (!rst_n)            odd_q <= 1'b0;
    else if (!interlace_i) odd_q <= 1'b0;
    else if (frame_stb_i)  odd_q <= ~odd_q;
  end

  always_comb begin
    word    = '0;
    word[0] = dma_busy_i;
    word[3] = vblank;
    word[4] = interlace_i && odd_q;
    word[5] = sprite_hit_i;
    word[8] = fifo_empty_i;
    word[9] = fifo_full_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_stb_i;
      if (rd_stb_i) rd_data_o <= word;
    end
  end

  AST_ODD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !interlace_i |=> !odd_q); // R7
  AST_ODD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (interlace_i && frame_stb_i) |=> (odd_q != $past(odd_q))); // R7
  AST_ODD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (interlace_i && !frame_stb_i) |=> $stable(odd_q)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> ($stable(rd_data_o) && !rd_valid_o)); // R8
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> rd_valid_o); // R8
  AST_DISP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !disp_en_i) |=> rd_data_o[3]); // R6
  AST_ACTIVE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && disp_en_i && (line_i < LINE_W'(NTSC_FIRST))) |=> !rd_data_o[3]); // R5
  AST_WRAP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && disp_en_i && (line_i == WRAP_LINE) && (slot_i == chg_slot)) |=> rd_data_o[3]); // R4
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && frame_stb_i && interlace_i) |=> (rd_data_o[4] == $past(odd_q))); // R10

endmodule

// File: tb/vid_status_flags_bench.sv
module vid_status_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] line_i = '0;
  logic [7:0] slot_i = '0;
  logic wide_i = 1'b0, pal_i = 1'b0, disp_en_i = 1'b1, interlace_i = 1'b0;
  logic frame_stb_i = 1'b0, rd_stb_i = 1'b0;
  logic dma_busy_i = 1'b0, sprite_hit_i = 1'b0, fifo_empty_i = 1'b0, fifo_full_i = 1'b0;
  logic [15:0] rd_data_o;
  logic rd_valid_o;
  int checks = 0;
  int errors = 0;

  vid_status_flags u_vid_status_flags (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .slot_i(slot_i), .wide_i(wide_i),
    .pal_i(pal_i), .disp_en_i(disp_en_i), .interlace_i(interlace_i),
    .frame_stb_i(frame_stb_i), .rd_stb_i(rd_stb_i), .dma_busy_i(dma_busy_i),
    .sprite_hit_i(sprite_hit_i), .fifo_empty_i(fifo_empty_i), .fifo_full_i(fifo_full_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_read(input logic [8:0] ln, input logic [7:0] sl);
    @(negedge clk);
    line_i = ln; slot_i = sl; rd_stb_i = 1'b1;
    @(negedge clk);
    rd_stb_i = 1'b0;
  endtask

  task automatic vb_check(input string req, input logic [8:0] ln, input logic [7:0] sl, input logic exp);
    do_read(ln, sl);
    check(req, {15'd0, rd_data_o[3]}, {15'd0, exp});
  endtask

  task automatic test_reset();
    check("R1 data", rd_data_o, 16'h0000);
    check("R1 valid", {15'd0, rd_valid_o}, 16'h0000);
    interlace_i = 1'b1;
    do_read(9'd10, 8'd0);
    check("R1 odd cleared", {15'd0, rd_data_o[4]}, 16'h0000);
    interlace_i = 1'b0;
  endtask

  task automatic test_body();
    wide_i = 1'b1; pal_i = 1'b0;
    vb_check("R2 ntsc 225", 9'd225, 8'd0, 1'b1);
    vb_check("R2 ntsc 300", 9'd300, 8'd100, 1'b1);
    vb_check("R2 ntsc 510", 9'd510, 8'd200, 1'b1);
    pal_i = 1'b1;
    vb_check("R2 pal 241", 9'd241, 8'd166, 1'b1);
    vb_check("R5 pal 230", 9'd230, 8'd0, 1'b0);
    vb_check("R5 pal 239", 9'd239, 8'd200, 1'b0);
    pal_i = 1'b0;
  endtask

  task automatic test_first_line();
    wide_i = 1'b1;
    vb_check("R3 wide 164", 9'd224, 8'd164, 1'b1);
    vb_check("R3 wide 165", 9'd224, 8'd165, 1'b0);
    vb_check("R3 wide 166", 9'd224, 8'd166, 1'b0);
    vb_check("R3 wide 167", 9'd224, 8'd167, 1'b1);
    vb_check("R3 wide 255", 9'd224, 8'd255, 1'b1);
    wide_i = 1'b0;
    vb_check("R3 narrow 131", 9'd224, 8'd131, 1'b1);
    vb_check("R3 narrow 132", 9'd224, 8'd132, 1'b0);
    vb_check("R3 narrow 133", 9'd224, 8'd133, 1'b0);
    vb_check("R3 narrow 134", 9'd224, 8'd134, 1'b1);
    wide_i = 1'b1; pal_i = 1'b1;
    vb_check("R3 pal 166", 9'd240, 8'd166, 1'b0);
    vb_check("R3 pal 167", 9'd240, 8'd167, 1'b1);
    pal_i = 1'b0;
  endtask

  task automatic test_wrap_line();
    wide_i = 1'b1;
    vb_check("R4 wide 0", 9'h1FF, 8'd0, 1'b0);
    vb_check("R4 wide 164", 9'h1FF, 8'd164, 1'b0);
    vb_check("R4 wide 165", 9'h1FF, 8'd165, 1'b1);
    vb_check("R4 wide 166", 9'h1FF, 8'd166, 1'b1);
    vb_check("R4 wide 167", 9'h1FF, 8'd167, 1'b0);
    wide_i = 1'b0;
    vb_check("R4 narrow 132", 9'h1FF, 8'd132, 1'b1);
    vb_check("R4 narrow 134", 9'h1FF, 8'd134, 1'b0);
  endtask

  task automatic test_active_and_disp();
    wide_i = 1'b1;
    vb_check("R5 line 0", 9'd0, 8'd0, 1'b0);
    vb_check("R5 line 100", 9'd100, 8'd170, 1'b0);
    vb_check("R5 line 223", 9'd223, 8'd200, 1'b0);
    disp_en_i = 1'b0;
    vb_check("R6 line 10", 9'd10, 8'd5, 1'b1);
    vb_check("R6 line 1FF", 9'h1FF, 8'd0, 1'b1);
    disp_en_i = 1'b1;
  endtask

  task automatic test_passthru_and_hold();
    dma_busy_i = 1'b1; sprite_hit_i = 1'b1; fifo_empty_i = 1'b1; fifo_full_i = 1'b1;
    do_read(9'd10, 8'd0);
    check("R9 fields", rd_data_o, 16'h0321);
    check("R8 valid pulse", {15'd0, rd_valid_o}, 16'h0001);
    dma_busy_i = 1'b0; sprite_hit_i = 1'b0; fifo_empty_i = 1'b0; fifo_full_i = 1'b0;
    line_i = 9'd300;
    repeat (3) @(negedge clk);
    check("R8 held", rd_data_o, 16'h0321);
    check("R8 valid low", {15'd0, rd_valid_o}, 16'h0000);
    fifo_empty_i = 1'b1;
    do_read(9'd300, 8'd0);
    check("R9 empty only", rd_data_o, 16'h0108);
    fifo_empty_i = 1'b0;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_stb_i = 1'b1;
    @(negedge clk);
    frame_stb_i = 1'b0;
  endtask

  task automatic test_field();
    interlace_i = 1'b1;
    do_read(9'd10, 8'd0);
    check("R7 start even", {15'd0, rd_data_o[4]}, 16'h0000);
    frame_pulse();
    do_read(9'd10, 8'd0);
    check("R7 odd after strobe", {15'd0, rd_data_o[4]}, 16'h0001);
    frame_pulse();
    do_read(9'd10, 8'd0);
    check("R7 even again", {15'd0, rd_data_o[4]}, 16'h0000);
    frame_pulse();
    interlace_i = 1'b0;
    do_read(9'd10, 8'd0);
    check("R7 off hides", {15'd0, rd_data_o[4]}, 16'h0000);
    frame_pulse();
    interlace_i = 1'b1;
    do_read(9'd10, 8'd0);
    check("R7 cleared by off", {15'd0, rd_data_o[4]}, 16'h0000);
  endtask

  task automatic test_collide();
    interlace_i = 1'b1;
    @(negedge clk);
    line_i = 9'd10; slot_i = 8'd0; rd_stb_i = 1'b1; frame_stb_i = 1'b1;
    @(negedge clk);
    rd_stb_i = 1'b0; frame_stb_i = 1'b0;
    check("R10 old parity", {15'd0, rd_data_o[4]}, 16'h0000);
    do_read(9'd10, 8'd0);
    check("R10 flip applied", {15'd0, rd_data_o[4]}, 16'h0001);
    @(negedge clk);
    interlace_i = 1'b0; rd_stb_i = 1'b1;
    @(negedge clk);
    rd_stb_i = 1'b0; interlace_i = 1'b1;
    check("R7 read with off", {15'd0, rd_data_o[4]}, 16'h0000);
    do_read(9'd10, 8'd0);
    check("R7 stays cleared", {15'd0, rd_data_o[4]}, 16'h0000);
    interlace_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_body();
    test_first_line();
    test_wrap_line();
    test_active_and_disp();
    test_passthru_and_hold();
    test_field();
    test_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule